// File: doc/BRIEF.md
# Boot-Overlaid Memory Bank Decoder

This block turns a 16-bit processor memory address into selects for a 32 KB RAM and three 8 KB ROM banks. It also produces the address each memory sees. A 3-bit region code drives the decode. The code normally comes from the top three address bits. When the overlay input is low, an expansion card supplies the code instead. The card can also inhibit RAM outright. Read data is steered from the RAM, from the ROM, or from a 0xFF default. Writes only ever reach the RAM.

A small power-up sequencer is part of the block. Reset may be held for any length of time. After it releases, the sequencer holds two processor halt outputs asserted for a set number of clock cycles. After a longer count it raises a power-up flag. Until that flag rises, every access is forced into the top ROM bank, so the processor boots from ROM wherever it fetches. The decode is combinational. Only the two delay counts are stored state.

Top module: `membank_top`

## Requirements
- R1: Once powered up, the region code is cpuAddr[15:13] while romOverlay is 1, and expRegion while romOverlay is 0.
- R2: While pwrUp is 0, the region code is forced to 7. romSel is 3'b100 and ramSel is 0 for every address, and writes have no effect on RAM contents.
- R3: Region codes 5, 6 and 7 raise romSel bit 0, 1 and 2 respectively (one-hot, otherwise 0). romAddr is cpuAddr[12:0].
- R4: ramSel is 1 exactly when bit 2 of the region code is 0 and expRamInhibit is 0. ramAddr equals cpuAddr in full.
- R5: rdData is romRdata when any ROM bank is selected, ramRdata when RAM is selected, and 8'hFF otherwise (region 4, or inhibited RAM).
- R6: ramWe is 1 exactly when cpuWrite is 1 and ramSel is 1. A write into a ROM region or the unmapped region leaves RAM unchanged.
- R7: cpuHalt and subHalt are 1 during reset and for HALT_CYCLES rising edges after reset releases, then 0, and they never reassert.
- R8: pwrUp is 0 during reset and rises after PWRUP_CYCLES rising edges following reset release (PWRUP_CYCLES > HALT_CYCLES), then stays 1.
- R9: expRamInhibit set removes the RAM select and its writes even for region codes 0 to 3. Reads there return 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor memory address |
| cpuWrite | input | 1 | Processor write request |
| romOverlay | input | 1 | 1: region from address bits; 0: region from expansion card |
| expRegion | input | 3 | Region code supplied by the expansion card |
| expRamInhibit | input | 1 | Expansion card disables RAM |
| ramRdata | input | 8 | Read data from RAM |
| romRdata | input | 8 | Read data from the selected ROM bank |
| ramSel | output | 1 | RAM chip select |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 16 | RAM address |
| romSel | output | 3 | One-hot ROM bank selects |
| romAddr | output | 13 | Bank-local ROM address |
| rdData | output | 8 | Read data returned to the processor |
| cpuHalt | output | 1 | Main processor halt |
| subHalt | output | 1 | Auxiliary processor halt |
| pwrUp | output | 1 | Power-up complete flag |

## Verification
The assertions check several properties on every cycle. The ROM selects stay one-hot or idle, and RAM and ROM are never selected together. Before power-up, every access lands in the top ROM bank. Once the halts release they stay released, and the power-up flag is sticky and never rises while the halts hold. The bench scenarios cover the rest. They check the exact cycle on which each delay expires, the region source switching between address and card, and the 0xFF default. They also show that writes aimed at ROM, at unmapped space or at inhibited RAM leave the RAM contents unchanged when read back later.

// File: rtl/membank_pkg.sv
package membank_pkg;
  // strobes from the sequencer to the decode datapath
  typedef struct packed {
    logic pwrUp;
    logic holdHalt;
  } seqStrobes_t;
endpackage

// File: rtl/membank_ctrl.sv
module membank_ctrl
  import membank_pkg::*;
#(
  parameter int unsigned HALT_CYCLES  = 8_800_000,
  parameter int unsigned PWRUP_CYCLES = 22_400_000
) (
  input  logic        clk,
  input  logic        rstN,
  output seqStrobes_t strobes
);
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] HALT_END  = CNT_W'(HALT_CYCLES);
  localparam logic [CNT_W-1:0] PWRUP_END = CNT_W'(PWRUP_CYCLES);

  logic [CNT_W-1:0] elapsed;

  // one saturating counter serves both delays
  always_ff @(posedge clk) begin
    if (!rstN)
      elapsed <= '0;
    else if (elapsed != PWRUP_END)
      elapsed <= elapsed + 1'b1;
  end

  always_comb begin
    strobes.holdHalt = (elapsed < HALT_END);
    strobes.pwrUp    = (elapsed == PWRUP_END);
  end

  AST_HALT_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.holdHalt |=> !strobes.holdHalt); // R7
  AST_PWRUP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pwrUp |=> strobes.pwrUp); // R8
  AST_PWRUP_AFTER_HALT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pwrUp |-> !strobes.holdHalt); // R8
endmodule

// File: rtl/membank_dp.sv
module membank_dp
  import membank_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int REGION_W   = 3,
  parameter int ROM_BANKS  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              strobes,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic                     cpuWrite,
  input  logic                     romOverlay,
  input  logic [REGION_W-1:0]      expRegion,
  input  logic                     expRamInhibit,
  input  logic [DATA_W-1:0]        ramRdata,
  input  logic [DATA_W-1:0]        romRdata,
  output logic                     ramSel,
  output logic                     ramWe,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [ROM_BANKS-1:0]     romSel,
  output logic [ADDR_W-REGION_W-1:0] romAddr,
  output logic [DATA_W-1:0]        rdData
);
  localparam int BANK_AW = ADDR_W - REGION_W;
  localparam int FIRST_ROM_CODE = (1 << REGION_W) - ROM_BANKS;
  localparam logic [REGION_W-1:0] BOOT_CODE = '1;

  logic [REGION_W-1:0] region;

  always_comb begin
    if (!strobes.pwrUp)
      region = BOOT_CODE;
    else if (romOverlay)
      region = cpuAddr[ADDR_W-1 -: REGION_W];
    else
      region = expRegion;
  end

  for (genvar g = 0; g < ROM_BANKS; g++) begin : g_romDec
    assign romSel[g] = (region == REGION_W'(FIRST_ROM_CODE + g));
  end

  always_comb begin
    ramSel  = !region[REGION_W-1] && !expRamInhibit;
    ramWe   = ramSel && cpuWrite;
    ramAddr = cpuAddr;
    romAddr = cpuAddr[BANK_AW-1:0];
    if (|romSel)
      rdData = romRdata;
    else if (ramSel)
      rdData = ramRdata;
    else
      rdData = '1;
  end

  AST_ROM_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(romSel)); // R3
  AST_NO_DUAL_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !(ramSel && (|romSel))); // R4
  AST_BOOT_TOP_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pwrUp |-> (romSel[ROM_BANKS-1] && !ramWe)); // R2
  AST_WRITE_RETURNS_RAM: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (rdData == ramRdata)); // R6
endmodule

// File: rtl/membank_top.sv
module membank_top
  import membank_pkg::*;
#(
  parameter int unsigned HALT_CYCLES  = 8_800_000,
  parameter int unsigned PWRUP_CYCLES = 22_400_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWrite,
  input  logic        romOverlay,
  input  logic [2:0]  expRegion,
  input  logic        expRamInhibit,
  input  logic [7:0]  ramRdata,
  input  logic [7:0]  romRdata,
  output logic        ramSel,
  output logic        ramWe,
  output logic [15:0] ramAddr,
  output logic [2:0]  romSel,
  output logic [12:0] romAddr,
  output logic [7:0]  rdData,
  output logic        cpuHalt,
  output logic        subHalt,
  output logic        pwrUp
);
  seqStrobes_t strobes;

  membank_ctrl #(
    .HALT_CYCLES (HALT_CYCLES),
    .PWRUP_CYCLES(PWRUP_CYCLES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  membank_dp #(
    .ADDR_W   (16),
    .DATA_W   (8),
    .REGION_W (3),
    .ROM_BANKS(3)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cpuAddr      (cpuAddr),
    .cpuWrite     (cpuWrite),
    .romOverlay   (romOverlay),
    .expRegion    (expRegion),
    .expRamInhibit(expRamInhibit),
    .ramRdata     (ramRdata),
    .romRdata     (romRdata),
    .ramSel       (ramSel),
    .ramWe        (ramWe),
    .ramAddr      (ramAddr),
    .romSel       (romSel),
    .romAddr      (romAddr),
    .rdData       (rdData)
  );

  assign cpuHalt = strobes.holdHalt;
  assign subHalt = strobes.holdHalt;
  assign pwrUp   = strobes.pwrUp;
endmodule

// File: tb/membank_top_tb.sv
module membank_top_tb_top;
  localparam int HALT_N  = 40;
  localparam int PWRUP_N = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWrite = 1'b0;
  logic        romOverlay = 1'b1;
  logic [2:0]  expRegion = '0;
  logic        expRamInhibit = 1'b0;
  logic [7:0]  ramRdata;
  logic [7:0]  romRdata;
  logic        ramSel, ramWe, cpuHalt, subHalt, pwrUp;
  logic [15:0] ramAddr;
  logic [2:0]  romSel;
  logic [12:0] romAddr;
  logic [7:0]  rdData;
  logic [7:0]  cpuWdata = '0;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  logic [7:0] ramMem [256];
  logic [7:0] refMem [256];

  always #2 clk = ~clk;

  membank_top #(.HALT_CYCLES(HALT_N), .PWRUP_CYCLES(PWRUP_N)) dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .romOverlay(romOverlay), .expRegion(expRegion), .expRamInhibit(expRamInhibit),
    .ramRdata(ramRdata), .romRdata(romRdata), .ramSel(ramSel), .ramWe(ramWe),
    .ramAddr(ramAddr), .romSel(romSel), .romAddr(romAddr), .rdData(rdData),
    .cpuHalt(cpuHalt), .subHalt(subHalt), .pwrUp(pwrUp)
  );

  function automatic logic [7:0] romByte(int bank, logic [12:0] a);
    return a[7:0] ^ 8'(bank * 37) ^ {3'b0, a[12:8]} ^ 8'h3C;
  endfunction

  // behavioural memories
  always_comb begin
    ramRdata = ramMem[ramAddr[7:0]];
    if (romSel[0])      romRdata = romByte(0, romAddr);
    else if (romSel[1]) romRdata = romByte(1, romAddr);
    else if (romSel[2]) romRdata = romByte(2, romAddr);
    else                romRdata = 8'hA5;
  end

  always @(posedge clk) begin
    if (ramWe) ramMem[ramAddr[7:0]] <= cpuWdata;
    if (rstN) edgeCnt <= edgeCnt + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expReg(logic [15:0] a, logic ov, logic [2:0] er, logic pu);
    if (!pu) return 3'd7;
    return ov ? a[15:13] : er;
  endfunction

  task automatic doAccess(logic [15:0] a, logic we, logic [7:0] wd,
                          logic ov, logic [2:0] er, logic inh);
    logic [2:0] reg3;
    logic pu, eRam;
    logic [2:0] eRom;
    logic [7:0] eRd;
    @(negedge clk);
    cpuAddr = a; cpuWrite = we; cpuWdata = wd;
    romOverlay = ov; expRegion = er; expRamInhibit = inh;
    #1;
    pu = (edgeCnt >= PWRUP_N);
    reg3 = expReg(a, ov, er, pu);
    eRam = !reg3[2] && !inh;
    eRom = (reg3 == 3'd5) ? 3'b001 : (reg3 == 3'd6) ? 3'b010 : (reg3 == 3'd7) ? 3'b100 : 3'b000;
    if (eRom != 0) eRd = romByte((reg3 == 3'd5) ? 0 : (reg3 == 3'd6) ? 1 : 2, a[12:0]);
    else if (eRam) eRd = refMem[a[7:0]];
    else eRd = 8'hFF;
    chk(pu ? "R3 romSel" : "R2 boot romSel", {29'b0, romSel}, {29'b0, eRom});
    chk(inh ? "R9 ramSel" : "R4 ramSel", {31'b0, ramSel}, {31'b0, eRam});
    chk("R6 ramWe", {31'b0, ramWe}, {31'b0, eRam && we});
    chk("R5 rdData", {24'b0, rdData}, {24'b0, eRd});
    if (eRom != 0) chk("R3 romAddr", {19'b0, romAddr}, {19'b0, a[12:0]});
    if (eRam) chk("R4 ramAddr", {16'b0, ramAddr}, {16'b0, a});
    if (pu && !inh) chk("R1 region source", {31'b0, ramSel || (|romSel)},
                        {31'b0, (reg3 != 3'd4)});
    if (eRam && we) refMem[a[7:0]] = wd;
  endtask

  task automatic chkSeq();
    chk("R7 cpuHalt", {31'b0, cpuHalt}, {31'b0, edgeCnt < HALT_N});
    chk("R7 subHalt", {31'b0, subHalt}, {31'b0, edgeCnt < HALT_N});
    chk("R8 pwrUp", {31'b0, pwrUp}, {31'b0, edgeCnt >= PWRUP_N});
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 256; i++) begin ramMem[i] = 8'h00; refMem[i] = 8'h00; end
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 halt in reset", {31'b0, cpuHalt && subHalt}, 32'd1);
    chk("R8 pwrUp in reset", {31'b0, pwrUp}, 32'd0);
    rstN = 1'b1;
    // boot phase: random accesses, all must land in the top ROM bank (R2)
    while (edgeCnt < PWRUP_N + 3) begin
      doAccess(16'($urandom), edgeCnt < PWRUP_N - 2 ? 1'($urandom) : 1'b0,
               8'($urandom), 1'($urandom), 3'($urandom), 1'b0);
      chkSeq();
    end
    // directed corners
    doAccess(16'h0012, 1, 8'h5A, 1, 3'd0, 0);  // R4 write RAM
    doAccess(16'h0012, 0, 8'h00, 1, 3'd0, 0);  // R5 read back
    doAccess(16'hA012, 1, 8'hEE, 1, 3'd0, 0);  // R6 ROM region write
    doAccess(16'h8012, 1, 8'hEE, 1, 3'd0, 0);  // R5 region 4 -> FF, R6 no write
    doAccess(16'hC123, 0, 8'h00, 1, 3'd0, 0);  // R3 bank 1
    doAccess(16'hFFFF, 0, 8'h00, 1, 3'd0, 0);  // R3 bank 2
    doAccess(16'hE012, 0, 8'h00, 0, 3'd1, 0);  // R1 card region RAM
    doAccess(16'h0012, 0, 8'h00, 0, 3'd5, 0);  // R1 card region ROM0
    doAccess(16'h0012, 1, 8'h77, 1, 3'd0, 1);  // R9 inhibited write
    doAccess(16'h0012, 0, 8'h00, 1, 3'd0, 0);  // R6 R9 value unchanged
    chk("R6 RAM kept after blocked writes", {24'b0, rdData}, 32'h5A);
    for (int i = 0; i < 3000; i++) begin
      doAccess({($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2), 13'($urandom)},
               1'($urandom), 8'($urandom), ($urandom % 4) != 0, 3'($urandom),
               ($urandom % 8) == 0);
      if (i % 500 == 0) chkSeq();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule